// File: doc/BRIEF.md
# SerDes Receive-Polarity and PLL Fix-up Sequencer

This block replaces a short piece of driver software that must run once after a link core leaves reset. On a start pulse it reads a protocol-layer status word through an indirect address/data register window and takes the receive-polarity-inverted flag from it. It then writes the SerDes receiver control register over a management-bus master port: the value forces the polarity and, if the status flag was set, inverts it. Last, it reads the SerDes PLL control register. If frequency detection is enabled there, it writes the same value back with that one bit cleared.

Two access styles are supported and chosen from the core revision input when the run starts. In the block-select style, every register access is preceded by a select write that names the target device, and each transaction may poll for completion for a long time. In the direct style the device number is carried in the access itself and the poll budget is short. If a transaction runs past its budget, the sequencer raises a sticky error, skips the rest of the program and finishes. The management serial engine and the indirect register target sit outside this block.

Top module: `serdes_fixup_seq`

## Requirements
- R1: After reset, busy, done, err, mg_start and ind_req are all low.
- R2: start is accepted only while idle (busy rises in the cycle after an accepted start); a start pulse during a run has no effect on the transactions issued or on the end of the run.
- R3: The status word is fetched in three indirect accesses in this order: write 0x204 to window offset 0x130, read offset 0x130 back, read offset 0x134. ind_req and the access fields stay stable until ind_ack.
- R4: The receiver control register (device 0x1F, register 1) is written with 0x00C0 when bit 4 of the status word is 1, and with 0x0080 when it is 0.
- R5: The PLL control register (device 0x1D, register 1) is then read. When bit 14 of the value read is 1, the value is written back with bit 14 cleared. When it is 0, no write is issued.
- R6: With core_rev >= 10, each access is preceded by a select write (mg_dev 0, mg_reg 0x1F, mg_wdata = device << 4), and the access itself carries mg_dev 0. With core_rev < 10, there is no select and mg_dev is the target device.
- R7: mg_done is not sampled during the first SETTLE (4) cycles after the mg_start cycle. After that it is sampled once per cycle, for 200 polls (block-select style) or 10 polls (direct style). A transaction succeeds if and only if mg_done is visible no later than SETTLE plus the poll limit cycles after its mg_start cycle.
- R8: On a timeout, err is set, no further transaction is issued, and the run ends with done.
- R9: err stays set after the run. It is cleared only when the next start is accepted.
- R10: done is a one-cycle pulse in the first cycle busy is low after a run. mg_start is a one-cycle pulse per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse for the fix-up program |
| core_rev | input | 8 | Core revision; selects the access style |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky timeout flag |
| ind_req | output | 1 | Indirect window access request |
| ind_we | output | 1 | Indirect access is a write |
| ind_addr | output | 12 | Indirect window offset |
| ind_wdata | output | 32 | Indirect write data |
| ind_ack | input | 1 | Indirect access complete (one cycle) |
| ind_rdata | input | 32 | Indirect read data, valid with ind_ack |
| mg_start | output | 1 | Launch a management transaction |
| mg_write | output | 1 | Transaction is a write |
| mg_dev | output | 5 | Management device field |
| mg_reg | output | 5 | Management register field |
| mg_wdata | output | 16 | Management write data |
| mg_done | input | 1 | Engine completion flag (level) |
| mg_rdata | input | 16 | Engine read data, valid with mg_done |

## Verification
The assertions check several rules on every cycle. A run only begins after a start and ends with done. err only rises inside a run and only falls when a new run begins. mg_start never lasts two cycles. A select-style access never carries a nonzero device. The wait counter never goes past its longest window. The indirect request holds its fields until it is acknowledged. The bench scenarios are needed for the rest: the values written for each polarity and each PLL bit pattern, the exact pass/fail edge of the poll budget in both styles, skipping the remaining steps after a timeout, and ignoring a start that arrives mid-run.

// File: rtl/serdes_fixup_pkg.sv
// Shared constants and state type for the SerDes fix-up sequencer.
// Assumes 12-bit indirect window offsets and 5-bit management fields.
package serdes_fixup_pkg;
    localparam int WIN_ADDR_OFS   = 'h130;  // indirect window: address register
    localparam int WIN_DATA_OFS   = 'h134;  // indirect window: data register
    localparam int PL_STATUS_ADDR = 'h204;  // protocol-layer status word
    localparam int POL_FLAG_BIT   = 4;      // polarity-inverted flag in status
    localparam logic [4:0] DEV_RXSIDE  = 5'h1F;
    localparam logic [4:0] DEV_PLLSIDE = 5'h1D;
    localparam logic [4:0] REG_CTRL    = 5'h01;
    localparam logic [4:0] REG_BLKSEL  = 5'h1F;
    localparam logic [15:0] RX_FORCE_ONLY = 16'h0080;
    localparam logic [15:0] RX_FORCE_INV  = 16'h00C0;
    localparam int FREQDET_BIT    = 14;

    typedef enum logic [2:0] {
        FX_IDLE, FX_STATUS, FX_RXWR, FX_PLLRD, FX_PLLWR, FX_FIN
    } fx_state_t;
endpackage

// File: rtl/fixup_ind_reader.sv
// Indirect-window reader: writes the target address into the window address
// register, reads it back, then reads the window data register.
// Assumes the target answers each request with a one-cycle ind_ack.
module fixup_ind_reader
    import serdes_fixup_pkg::*;
#(
    parameter int IAW = 12,
    parameter int IDW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    output logic           ind_req,
    output logic           ind_we,
    output logic [IAW-1:0] ind_addr,
    output logic [IDW-1:0] ind_wdata,
    input  logic           ind_ack,
    input  logic [IDW-1:0] ind_rdata,
    output logic           fin,
    output logic [IDW-1:0] word
);
    typedef enum logic [1:0] {IR_IDLE, IR_SETADDR, IR_READBACK, IR_FETCH} ir_t;
    ir_t st;

    // Step through the three window accesses, advancing on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= IR_IDLE;
            fin  <= 1'b0;
            word <= '0;
        end else begin
            fin <= 1'b0;
            case (st)
                IR_IDLE:     if (go) st <= IR_SETADDR;
                IR_SETADDR:  if (ind_ack) st <= IR_READBACK;
                IR_READBACK: if (ind_ack) st <= IR_FETCH;
                IR_FETCH: if (ind_ack) begin
                    word <= ind_rdata;
                    fin  <= 1'b1;
                    st   <= IR_IDLE;
                end
                default:     st <= IR_IDLE;
            endcase
        end
    end

    // Drive the request fields from the current step.
    always_comb begin
        ind_req   = (st != IR_IDLE);
        ind_we    = (st == IR_SETADDR);
        ind_addr  = (st == IR_FETCH) ? IAW'(WIN_DATA_OFS) : IAW'(WIN_ADDR_OFS);
        ind_wdata = (st == IR_SETADDR) ? IDW'(PL_STATUS_ADDR) : '0;
    end

    assert_ind_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && !ind_ack) |=> (ind_req && $stable(ind_addr) && $stable(ind_we)));
endmodule

// File: rtl/fixup_mgmt_step.sv
// One management register access, with an optional block-select write first.
// Each transaction: one mg_start cycle, SETTLE cycles without sampling, then
// one mg_done poll per cycle up to the style's poll limit.
// Assumes the engine clears mg_done when it sees mg_start.
module fixup_mgmt_step
    import serdes_fixup_pkg::*;
#(
    parameter int SETTLE    = 4,
    parameter int POLLS_NEW = 200,
    parameter int POLLS_OLD = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        new_style,
    input  logic        is_write,
    input  logic [4:0]  dev,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    output logic        mg_start,
    output logic        mg_write,
    output logic [4:0]  mg_dev,
    output logic [4:0]  mg_reg,
    output logic [15:0] mg_wdata,
    input  logic        mg_done,
    input  logic [15:0] mg_rdata,
    output logic        fin_ok,
    output logic        fin_tmo,
    output logic [15:0] rdata
);
    localparam int WAIT_MAX = SETTLE + ((POLLS_NEW > POLLS_OLD) ? POLLS_NEW : POLLS_OLD);
    localparam int CW       = $clog2(WAIT_MAX + 1);

    typedef enum logic [2:0] {MS_IDLE, MS_SEL, MS_SELW, MS_ACC, MS_ACCW} ms_t;
    ms_t          st;
    logic         new_q, wr_q;
    logic [4:0]   dev_q, reg_q;
    logic [15:0]  wd_q;
    logic [CW-1:0] wcnt, lim;
    logic         polled_done;

    assign lim         = new_q ? CW'(SETTLE + POLLS_NEW) : CW'(SETTLE + POLLS_OLD);
    assign polled_done = (wcnt > CW'(SETTLE)) && mg_done;

    // Sequence select and access transactions and time out their polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= MS_IDLE; new_q <= 1'b0; wr_q <= 1'b0;
            dev_q <= '0; reg_q <= '0; wd_q <= '0; wcnt <= '0;
            fin_ok <= 1'b0; fin_tmo <= 1'b0; rdata <= '0;
        end else begin
            fin_ok  <= 1'b0;
            fin_tmo <= 1'b0;
            case (st)
                MS_IDLE: if (go) begin
                    new_q <= new_style; wr_q <= is_write;
                    dev_q <= dev; reg_q <= regad; wd_q <= wdata;
                    st    <= new_style ? MS_SEL : MS_ACC;
                end
                MS_SEL: begin st <= MS_SELW; wcnt <= CW'(1); end
                MS_ACC: begin st <= MS_ACCW; wcnt <= CW'(1); end
                MS_SELW, MS_ACCW: begin
                    if (polled_done) begin
                        wcnt <= '0;
                        if (st == MS_SELW) st <= MS_ACC;
                        else begin
                            rdata  <= mg_rdata;
                            fin_ok <= 1'b1;
                            st     <= MS_IDLE;
                        end
                    end else if (wcnt == lim) begin
                        wcnt    <= '0;
                        fin_tmo <= 1'b1;
                        st      <= MS_IDLE;
                    end else begin
                        wcnt <= wcnt + CW'(1);
                    end
                end
                default: st <= MS_IDLE;
            endcase
        end
    end

    // Present the transaction fields for the select or the access.
    always_comb begin
        mg_start = (st == MS_SEL) || (st == MS_ACC);
        mg_write = (st == MS_SEL) ? 1'b1 : wr_q;
        mg_dev   = ((st == MS_SEL) || new_q) ? 5'd0 : dev_q;
        mg_reg   = (st == MS_SEL) ? REG_BLKSEL : reg_q;
        mg_wdata = (st == MS_SEL) ? {6'd0, dev_q, 4'd0} : (wr_q ? wd_q : 16'd0);
    end

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mg_start |=> !mg_start);
    assert_sel_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_start && new_q) |-> (mg_dev == 5'd0));
    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= CW'(WAIT_MAX));
endmodule

// File: rtl/serdes_fixup_seq.sv
// Top of the fix-up sequencer: status fetch, receiver polarity write, PLL
// read and conditional frequency-detect clear. Access style is fixed per run
// from core_rev. Assumes start is a synchronous pulse.
module serdes_fixup_seq
    import serdes_fixup_pkg::*;
#(
    parameter int REV_W     = 8,
    parameter int NEW_REV   = 10,
    parameter int SETTLE    = 4,
    parameter int POLLS_NEW = 200,
    parameter int POLLS_OLD = 10,
    parameter int IAW       = 12,
    parameter int IDW       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REV_W-1:0] core_rev,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             ind_req,
    output logic             ind_we,
    output logic [IAW-1:0]   ind_addr,
    output logic [IDW-1:0]   ind_wdata,
    input  logic             ind_ack,
    input  logic [IDW-1:0]   ind_rdata,
    output logic             mg_start,
    output logic             mg_write,
    output logic [4:0]       mg_dev,
    output logic [4:0]       mg_reg,
    output logic [15:0]      mg_wdata,
    input  logic             mg_done,
    input  logic [15:0]      mg_rdata
);
    fx_state_t    st;
    logic         go_ind, go_mg, new_q;
    logic         ind_fin;
    logic [IDW-1:0] ind_word;
    logic         unused_ind_bits;
    logic         step_ok, step_tmo;
    logic [15:0]  step_rd;
    logic         s_wr;
    logic [4:0]   s_dev;
    logic [15:0]  s_wd;
    logic         pol_q;

    assign unused_ind_bits = ^ind_word;
    assign busy = (st != FX_IDLE);

    fixup_ind_reader #(.IAW(IAW), .IDW(IDW)) u_ind (
        .clk(clk), .rst_n(rst_n), .go(go_ind),
        .ind_req(ind_req), .ind_we(ind_we), .ind_addr(ind_addr),
        .ind_wdata(ind_wdata), .ind_ack(ind_ack), .ind_rdata(ind_rdata),
        .fin(ind_fin), .word(ind_word)
    );

    // Choose the access fields for the step the program is in.
    always_comb begin
        s_wr  = 1'b1;
        s_dev = DEV_PLLSIDE;
        s_wd  = 16'd0;
        case (st)
            FX_RXWR:  begin s_dev = DEV_RXSIDE; s_wd = pol_q ? RX_FORCE_INV : RX_FORCE_ONLY; end
            FX_PLLRD: s_wr = 1'b0;
            FX_PLLWR: s_wd = step_rd & ~(16'd1 << FREQDET_BIT);
            default:  ;
        endcase
    end

    fixup_mgmt_step #(.SETTLE(SETTLE), .POLLS_NEW(POLLS_NEW), .POLLS_OLD(POLLS_OLD)) u_mg (
        .clk(clk), .rst_n(rst_n), .go(go_mg), .new_style(new_q),
        .is_write(s_wr), .dev(s_dev), .regad(REG_CTRL), .wdata(s_wd),
        .mg_start(mg_start), .mg_write(mg_write), .mg_dev(mg_dev),
        .mg_reg(mg_reg), .mg_wdata(mg_wdata), .mg_done(mg_done),
        .mg_rdata(mg_rdata), .fin_ok(step_ok), .fin_tmo(step_tmo), .rdata(step_rd)
    );

    // Program sequencer: advance on step completion, abort to finish on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FX_IDLE; go_ind <= 1'b0; go_mg <= 1'b0;
            new_q <= 1'b0; pol_q <= 1'b0; done <= 1'b0; err <= 1'b0;
        end else begin
            go_ind <= 1'b0;
            go_mg  <= 1'b0;
            done   <= 1'b0;
            case (st)
                FX_IDLE: if (start) begin
                    err    <= 1'b0;
                    new_q  <= (core_rev >= REV_W'(NEW_REV));
                    go_ind <= 1'b1;
                    st     <= FX_STATUS;
                end
                FX_STATUS: if (ind_fin) begin
                    pol_q <= ind_word[POL_FLAG_BIT];
                    go_mg <= 1'b1;
                    st    <= FX_RXWR;
                end
                FX_RXWR: begin
                    if (step_ok) begin go_mg <= 1'b1; st <= FX_PLLRD; end
                    else if (step_tmo) begin err <= 1'b1; st <= FX_FIN; end
                end
                FX_PLLRD: begin
                    if (step_ok) begin
                        if (step_rd[FREQDET_BIT]) begin go_mg <= 1'b1; st <= FX_PLLWR; end
                        else st <= FX_FIN;
                    end else if (step_tmo) begin err <= 1'b1; st <= FX_FIN; end
                end
                FX_PLLWR: begin
                    if (step_ok) st <= FX_FIN;
                    else if (step_tmo) begin err <= 1'b1; st <= FX_FIN; end
                end
                FX_FIN: begin done <= 1'b1; st <= FX_IDLE; end
                default: st <= FX_IDLE;
            endcase
        end
    end

    assert_run_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_err_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> busy);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $rose(busy));
endmodule

// File: tb/sim_serdes_fixup_seq.sv
module sim_serdes_fixup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 4, POLLS_NEW = 200, POLLS_OLD = 10;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] core_rev = 8'd0;
    logic busy, done, err, ind_req, ind_we, ind_ack = 1'b0;
    logic [11:0] ind_addr;
    logic [31:0] ind_wdata, ind_rdata = 32'd0;
    logic mg_start, mg_write, mg_done = 1'b0;
    logic [4:0] mg_dev, mg_reg;
    logic [15:0] mg_wdata, mg_rdata = 16'd0;

    int n_chk = 0, n_fail = 0;

    serdes_fixup_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .core_rev(core_rev),
        .busy(busy), .done(done), .err(err),
        .ind_req(ind_req), .ind_we(ind_we), .ind_addr(ind_addr),
        .ind_wdata(ind_wdata), .ind_ack(ind_ack), .ind_rdata(ind_rdata),
        .mg_start(mg_start), .mg_write(mg_write), .mg_dev(mg_dev),
        .mg_reg(mg_reg), .mg_wdata(mg_wdata), .mg_done(mg_done), .mg_rdata(mg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Management engine model
    int eng_lat = 4, e_cnt = 0, txn_cnt = 0, rx_wr = 0, pll_wr = 0, pll_rd = 0, proto_bad = 0;
    logic exp_new = 1'b0, sel_pend = 1'b0, is_sel;
    logic [4:0] sel_blk = 5'd0, tgt;
    logic [15:0] rx_reg = 16'd0, pll_reg = 16'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mg_done <= 1'b0; e_cnt = 0;
        end else if (mg_start) begin
            mg_done <= 1'b0; e_cnt = eng_lat - 1; txn_cnt++;
            is_sel = 1'b0; tgt = mg_dev;
            if (exp_new) begin
                if (mg_write && mg_dev == 5'd0 && mg_reg == 5'h1F) begin
                    is_sel = 1'b1; sel_blk = mg_wdata[8:4]; sel_pend = 1'b1;
                    if (mg_wdata[15:9] != 0 || mg_wdata[3:0] != 0) proto_bad++;
                end else begin
                    if (!sel_pend || mg_dev != 5'd0) proto_bad++;
                    sel_pend = 1'b0; tgt = sel_blk;
                end
            end
            if (!is_sel) begin
                if (tgt == 5'h1F && mg_reg == 5'd1 && mg_write) begin rx_reg = mg_wdata; rx_wr++; end
                else if (tgt == 5'h1D && mg_reg == 5'd1) begin
                    if (mg_write) begin pll_reg = mg_wdata; pll_wr++; end
                    else begin mg_rdata <= pll_reg; pll_rd++; end
                end else proto_bad++;
            end
        end else if (e_cnt > 0) begin
            if (e_cnt == 1) mg_done <= 1'b1;
            e_cnt--;
        end
    end

    // Indirect window target model
    int i_cnt = 0, i_lat = 1, ind_bad = 0;
    logic [31:0] win_addr = 32'd0, status_val = 32'd0;
    logic readback_seen = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ind_ack <= 1'b0; i_cnt = 0;
        end else if (ind_ack) begin
            ind_ack <= 1'b0; i_cnt = 0;
        end else if (ind_req) begin
            if (i_cnt >= i_lat) begin
                ind_ack <= 1'b1;
                if (ind_we && ind_addr == 12'h130) begin win_addr = ind_wdata; readback_seen = 1'b0; end
                else if (!ind_we && ind_addr == 12'h130) begin ind_rdata <= win_addr; readback_seen = 1'b1; end
                else if (!ind_we && ind_addr == 12'h134) begin
                    if (readback_seen && win_addr == 32'h204) ind_rdata <= status_val;
                    else begin ind_rdata <= 32'd0; ind_bad++; end
                end else ind_bad++;
            end else i_cnt++;
        end
    end

    function automatic logic [15:0] exp_rx(input logic [31:0] s);
        return s[4] ? 16'h00C0 : 16'h0080;
    endfunction
    function automatic logic [15:0] exp_pll(input logic [15:0] v);
        return v[14] ? (v & 16'hBFFF) : v;
    endfunction
    function automatic int exp_txn(input logic nw, input logic [15:0] v);
        return (nw ? 2 : 1) * (2 + int'(v[14]));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_now();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Launch one run and wait for done; optional extra start pulse mid-run.
    task automatic run_seq(input int rev, input logic [31:0] st_word, input logic [15:0] pll0,
                           input int lat, input int extra_at);
        bit seen = 0;
        core_rev = 8'(rev); exp_new = (rev >= 10); eng_lat = lat;
        status_val = st_word; pll_reg = pll0; rx_reg = 16'd0;
        txn_cnt = 0; rx_wr = 0; pll_wr = 0; pll_rd = 0; proto_bad = 0; ind_bad = 0;
        sel_pend = 1'b0; i_lat = $urandom_range(0, 3);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < WD_CYCLES; c++) begin
            if (c == extra_at) start = 1'b1;
            else start = 1'b0;
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        start = 1'b0;
        if (!seen) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual no-done expected done");
            finish_now();
        end
    endtask

    task automatic check_good(input int rev, input logic [31:0] s, input logic [15:0] v);
        check("R4 rx value", 32'(rx_reg), 32'(exp_rx(s)));
        check("R5 pll value", 32'(pll_reg), 32'(exp_pll(v)));
        check("R5 pll writes", 32'(pll_wr), 32'(v[14]));
        check("R6 txn count", 32'(txn_cnt), 32'(exp_txn(rev >= 10, v)));
        check("R6 protocol", 32'(proto_bad), 32'd0);
        check("R3 window order", 32'(ind_bad), 32'd0);
        check("R8 err clear", 32'(err), 32'd0);
        check("R10 busy low at done", 32'(busy), 32'd0);
        @(negedge clk);
        check("R10 done pulse", 32'(done), 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {27'd0, busy, done, err, mg_start, ind_req}, 32'd0);

        // Random runs, both styles, latency inside every budget
        for (int k = 0; k < 24; k++) begin
            int rev = $urandom_range(5, 15);
            logic [31:0] s = $urandom;
            logic [15:0] v = 16'($urandom);
            run_seq(rev, s, v, $urandom_range(2, 14), -1);
            check_good(rev, s, v);
        end

        // Directed polarity and PLL patterns (R4, R5)
        run_seq(9, 32'h0000_0010, 16'h4000, 3, -1); check_good(9, 32'h10, 16'h4000);
        run_seq(10, 32'hFFFF_FFEF, 16'hBFFF, 3, -1); check_good(10, 32'hFFFFFFEF, 16'hBFFF);

        // R7 poll edge, direct style
        run_seq(9, 32'h10, 16'h7123, SETTLE + POLLS_OLD, -1);
        check_good(9, 32'h10, 16'h7123);
        run_seq(9, 32'h10, 16'h7123, SETTLE + POLLS_OLD + 1, -1);
        check("R7 old limit exceeded -> err", 32'(err), 32'd1);
        check("R8 steps skipped", 32'(txn_cnt), 32'd1);
        check("R8 no pll access", 32'(pll_rd + pll_wr), 32'd0);
        repeat (6) @(negedge clk);
        check("R9 err sticky", 32'(err), 32'd1);
        run_seq(9, 32'h0, 16'h0001, 5, -1);
        check_good(9, 32'h0, 16'h0001);

        // R7 poll edge, block-select style
        run_seq(10, 32'h0, 16'h4444, SETTLE + POLLS_NEW, -1);
        check_good(10, 32'h0, 16'h4444);
        run_seq(12, 32'h0, 16'h4444, SETTLE + POLLS_NEW + 1, -1);
        check("R7 new limit exceeded -> err", 32'(err), 32'd1);
        check("R8 select timeout skips", 32'(txn_cnt), 32'd1);
        check("R8 no rx write", 32'(rx_wr), 32'd0);

        // R2 start during a run is ignored
        begin
            bit rose = 0;
            run_seq(11, 32'h10, 16'h4001, 6, 20);
            check_good(11, 32'h10, 16'h4001);
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (busy) rose = 1;
            end
            check("R2 no second run", 32'(rose), 32'd0);
        end

        finish_now();
    end
endmodule